// File: doc/BRIEF.md
# NAND Page DMA Engine

This block moves one whole flash page between a NAND device and system memory without processor involvement. A page is split into a main data area of fixed size (`DATA_BYTES`) and a spare area whose length software sets. Each area has its own memory base address and its own enable. Software loads the command pair, the row address, both base addresses and the spare length, then writes the control word with its start bit set. The engine sends the command and address bytes over a byte stream towards the flash. It then moves page bytes between the flash byte streams and a burst-capable 32-bit memory port.

For a read, the engine sends the setup command, the address bytes and the confirm command. It waits for the ready/busy line to return high, then collects bytes. It packs them four at a time into words, least significant byte first, and writes them to memory. For a program, it sends the data-input command and the address bytes. It fetches words from memory and sends their bytes, least significant first. Finally it sends the program-confirm command and waits for ready/busy before it finishes. On completion the start bit drops, a sticky done status bit is set, and an interrupt line reflects the enabled status bits.

Every stream uses valid/ready. A transfer takes place on a clock edge where both are high. A source that raises valid keeps valid and its payload unchanged until ready is seen. The engine's valid and payload outputs never depend combinationally on the ready inputs.

Top module: `nand_page_dma`

## Requirements
- R1: After reset, every register reads 0, `irq` is 0, `fl_ce` is 0, and no valid output (`fl_tx_valid`, `mem_cmd_valid`, `mem_wvalid`) is high.
- R2: A transfer starts with one command byte (kind 0) equal to bits 7:0 of the command register (index 1). Address bytes (kind 1) follow. Control bit 7 set gives four address bytes and clear gives five. The first two are 0x00, the next are row bits 23:16 and 31:24 (index 2), and the fifth is bits 7:0 of index 3.
- R3: With control bit 1 clear (read), the address bytes are followed by command byte bits 15:8. No flash byte is accepted on the receive stream until `fl_rb` has been seen high after that confirm.
- R4: In a read, received bytes are packed least-significant-byte first into 32-bit words. The words are written to consecutive addresses from the data base (index 4, low two bits forced to 0) for `DATA_BYTES` bytes. They are then written from the spare base (index 5) for the spare length, which is bits 27:16 of index 6 in bytes, a multiple of 4.
- R5: In a program (control bit 1 set), words read from memory are sent as data bytes (kind 2), least significant first, data area before spare area. Command byte bits 15:8 follows, and the transfer ends only once `fl_rb` is high.
- R6: Control bit 2 enables the data area and bit 3 the spare area. A disabled or zero-length area moves no bytes on either side.
- R7: Each memory burst has min(M, words left in the area) beats. M is 16 if control bit 6 is set, else 8 if bit 5 is set, else 4 if bit 4 is set, else 1. A burst never spans two areas.
- R8: Writing the control register (index 0) with bit 0 set starts a transfer. Bit 0 reads back 1 while it runs and 0 once it ends.
- R9: Completion sets bit 9 of the status register (index 8). Writing 1 to bit 9 of the clear register (index 9) clears it, but a completion in the same cycle keeps it set.
- R10: `irq` is high exactly when some bit of status AND enable (index 7, bits 9, 6, 5) is set.
- R11: Writes to indices 0 to 6 are ignored while a transfer runs.
- R12: While a transfer runs, `fl_ce` is one-hot at the chip number in control bits 9:8. When idle it is 0.
- R13: Every valid output of the engine holds its payload stable until accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register word index |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data (combinational from index) |
| irq | output | 1 | Interrupt, status AND enable |
| fl_ce | output | 4 | One-hot chip enable, active high |
| fl_rb | input | 1 | Flash ready/busy, 1 = ready |
| fl_tx_valid | output | 1 | Byte toward flash valid |
| fl_tx_ready | input | 1 | Byte toward flash accepted |
| fl_tx_kind | output | 2 | 0 command, 1 address, 2 data |
| fl_tx_data | output | 8 | Byte toward flash |
| fl_rx_valid | input | 1 | Byte from flash valid |
| fl_rx_ready | output | 1 | Engine takes byte from flash |
| fl_rx_data | input | 8 | Byte from flash |
| mem_cmd_valid | output | 1 | Burst request valid |
| mem_cmd_ready | input | 1 | Burst request accepted |
| mem_cmd_addr | output | AW | Burst start byte address |
| mem_cmd_beats | output | 5 | Burst length in words (1 to 16) |
| mem_cmd_write | output | 1 | 1 = burst writes memory |
| mem_wvalid | output | 1 | Write word valid |
| mem_wready | input | 1 | Write word accepted |
| mem_wdata | output | 32 | Write word |
| mem_rvalid | input | 1 | Read word valid |
| mem_rready | output | 1 | Engine takes read word |
| mem_rdata | input | 32 | Read word |

## Verification
The assertions watch on every cycle that the flash byte and burst request outputs stay stable under back-pressure. They check that burst lengths stay within 1 to 16 and within the words left in the area, and that the receive and memory-read sides open only in the matching direction. They also check the chip enables against the busy state, that start raises busy and completion clears it, that the done status wins over a clear, and that config writes during a run leave state unchanged. Only the bench scenarios can show the exact command, address and data byte order, the word packing against memory contents, the burst split per area, and the wait for ready/busy. The same applies to the handling of disabled areas and to the interrupt under different enables, all under random stalls on every stream.

// File: rtl/nand_dma_pkg.sv
package nand_dma_pkg;
  localparam int RG_W = 4;
  localparam int CS_W = 2;

  // register word indices
  localparam logic [RG_W-1:0] RG_CTRL  = 4'd0;
  localparam logic [RG_W-1:0] RG_CMD   = 4'd1;
  localparam logic [RG_W-1:0] RG_ROW   = 4'd2;
  localparam logic [RG_W-1:0] RG_ROWHI = 4'd3;
  localparam logic [RG_W-1:0] RG_DBASE = 4'd4;
  localparam logic [RG_W-1:0] RG_SBASE = 4'd5;
  localparam logic [RG_W-1:0] RG_LEN   = 4'd6;
  localparam logic [RG_W-1:0] RG_IEN   = 4'd7;
  localparam logic [RG_W-1:0] RG_ISTAT = 4'd8;
  localparam logic [RG_W-1:0] RG_ICLR  = 4'd9;

  localparam int IRQ_DONE  = 9;
  localparam int IRQ_UNCOR = 6;
  localparam int IRQ_COR   = 5;
  localparam int LEN_LSB   = 16;

  typedef enum logic [1:0] {
    TK_CMD  = 2'd0,
    TK_ADDR = 2'd1,
    TK_DATA = 2'd2
  } tx_kind_e;

  typedef struct packed {
    logic [CS_W-1:0] cs;
    logic            four_cyc;
    logic [2:0]      burst_en;  // {x16, x8, x4}
    logic            spare_en;
    logic            data_en;
    logic            prog;
  } xfer_cfg_t;
endpackage

// File: rtl/nand_dma_regs.sv
module nand_dma_regs
  import nand_dma_pkg::*;
#(
  parameter int AW    = 32,
  parameter int LEN_W = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [RG_W-1:0] addr,
  input  logic [31:0]     wdata,
  output logic [31:0]     rdata,
  output logic            irq,
  output xfer_cfg_t       cfg,
  output logic [7:0]      cmd_first,
  output logic [7:0]      cmd_conf,
  output logic [15:0]     row_lo,
  output logic [7:0]      row_hi,
  output logic [AW-1:0]   dbase,
  output logic [AW-1:0]   sbase,
  output logic [LEN_W-1:0] slen,
  output logic            go,
  output logic            busy,
  input  logic            done
);
  localparam logic [9:0] IRQ_MASK = (10'd1 << IRQ_DONE) | (10'd1 << IRQ_UNCOR) | (10'd1 << IRQ_COR);

  logic [9:1]       ctrl_q;
  logic             busy_q, go_q;
  logic [15:0]      cmd_q, row_q;
  logic [7:0]       rowhi_q;
  logic [AW-1:0]    dbase_q, sbase_q;
  logic [LEN_W-1:0] slen_q;
  logic [9:0]       ien_q, ist_q, clr_v, set_v;
  logic             wr_cfg;

  assign wr_cfg = we && !busy_q;
  assign clr_v  = (we && addr == RG_ICLR) ? wdata[9:0] : 10'd0;
  assign set_v  = done ? (10'd1 << IRQ_DONE) : 10'd0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0; busy_q <= 1'b0; go_q <= 1'b0;
      cmd_q <= '0; row_q <= '0; rowhi_q <= '0;
      dbase_q <= '0; sbase_q <= '0; slen_q <= '0;
      ien_q <= '0; ist_q <= '0;
    end else begin
      go_q <= 1'b0;
      if (done) busy_q <= 1'b0;
      if (wr_cfg) begin
        case (addr)
          RG_CTRL: begin
            ctrl_q <= wdata[9:1];
            if (wdata[0]) begin
              busy_q <= 1'b1;
              go_q   <= 1'b1;
            end
          end
          RG_CMD:   cmd_q   <= wdata[15:0];
          RG_ROW:   row_q   <= wdata[31:16];
          RG_ROWHI: rowhi_q <= wdata[7:0];
          RG_DBASE: dbase_q <= {wdata[AW-1:2], 2'b00};
          RG_SBASE: sbase_q <= {wdata[AW-1:2], 2'b00};
          RG_LEN:   slen_q  <= wdata[LEN_LSB +: LEN_W];
          default: ;
        endcase
      end
      if (we && addr == RG_IEN) ien_q <= wdata[9:0] & IRQ_MASK;
      ist_q <= ((ist_q & ~clr_v) | set_v) & IRQ_MASK;
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      RG_CTRL:  rdata[9:0] = {ctrl_q, busy_q};
      RG_CMD:   rdata[15:0] = cmd_q;
      RG_ROW:   rdata[31:16] = row_q;
      RG_ROWHI: rdata[7:0] = rowhi_q;
      RG_DBASE: rdata[AW-1:0] = dbase_q;
      RG_SBASE: rdata[AW-1:0] = sbase_q;
      RG_LEN:   rdata[LEN_LSB +: LEN_W] = slen_q;
      RG_IEN:   rdata[9:0] = ien_q;
      RG_ISTAT: rdata[9:0] = ist_q;
      default:  rdata = '0;
    endcase
  end

  assign irq       = |(ist_q & ien_q);
  assign cfg       = xfer_cfg_t'(ctrl_q);
  assign cmd_first = cmd_q[7:0];
  assign cmd_conf  = cmd_q[15:8];
  assign row_lo    = row_q;
  assign row_hi    = rowhi_q;
  assign dbase     = dbase_q;
  assign sbase     = sbase_q;
  assign slen      = slen_q;
  assign go        = go_q;
  assign busy      = busy_q;

  // R8
  go_busy_chk: assert property (@(posedge clk) disable iff (!rst_n) go_q |-> busy_q);
  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !busy_q);
  // R9
  done_wins_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> ist_q[IRQ_DONE]);
  // R11
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && we && addr == RG_DBASE) |=> $stable(dbase_q));
endmodule

// File: rtl/nand_dma_burst.sv
module nand_dma_burst #(
  parameter int LEN_W = 12
) (
  input  logic [2:0]       burst_en,
  input  logic [LEN_W-1:0] words_left,
  output logic [4:0]       beats
);
  logic [4:0]       max_b;
  logic [LEN_W-1:0] max_w;

  always_comb begin
    if (burst_en[2])      max_b = 5'd16;
    else if (burst_en[1]) max_b = 5'd8;
    else if (burst_en[0]) max_b = 5'd4;
    else                  max_b = 5'd1;
    max_w = LEN_W'(max_b);
    beats = (words_left < max_w) ? 5'(words_left) : max_b;
  end
endmodule

// File: rtl/nand_dma_seq.sv
module nand_dma_seq
  import nand_dma_pkg::*;
#(
  parameter int AW         = 32,
  parameter int LEN_W      = 12,
  parameter int DATA_BYTES = 2048
) (
  input  logic             clk,
  input  logic             rst_n,
  input  xfer_cfg_t        cfg,
  input  logic [7:0]       cmd_first,
  input  logic [7:0]       cmd_conf,
  input  logic [15:0]      row_lo,
  input  logic [7:0]       row_hi,
  input  logic [AW-1:0]    dbase,
  input  logic [AW-1:0]    sbase,
  input  logic [LEN_W-1:0] slen,
  input  logic             go,
  output logic             done,
  input  logic             fl_rb,
  output logic             tx_valid,
  input  logic             tx_ready,
  output tx_kind_e         tx_kind,
  output logic [7:0]       tx_data,
  input  logic             rx_valid,
  output logic             rx_ready,
  input  logic [7:0]       rx_data,
  output logic             cmd_valid,
  input  logic             cmd_ready,
  output logic [AW-1:0]    cmd_addr,
  output logic [4:0]       cmd_beats,
  output logic             cmd_write,
  output logic             wvalid,
  input  logic             wready,
  output logic [31:0]      wdata,
  input  logic             rvalid,
  output logic             rready,
  input  logic [31:0]      rdata
);
  localparam logic [LEN_W-1:0] DATA_WORDS = LEN_W'(DATA_BYTES / 4);

  typedef enum logic [3:0] {
    S_IDLE, S_CMD1, S_ADDR, S_CONF_R, S_WAIT_R, S_AREA, S_BURST,
    S_RXB, S_MWR, S_MRD, S_TXB, S_CONF_P, S_WAIT_P, S_FIN
  } st_e;

  st_e              st;
  logic [2:0]       acyc;
  logic [1:0]       area_idx, bidx;
  logic [AW-1:0]    addr_q;
  logic [LEN_W-1:0] words_q;
  logic [4:0]       beats_q, plan_beats;
  logic [31:0]      buf_q;
  logic [2:0]       last_acyc;
  logic [7:0]       addr_byte;
  logic             area_on;
  logic [AW-1:0]    area_base;
  logic [LEN_W-1:0] area_words;
  st_e              after_beat;

  nand_dma_burst #(.LEN_W(LEN_W)) u_plan (
    .burst_en  (cfg.burst_en),
    .words_left(words_q),
    .beats     (plan_beats)
  );

  assign last_acyc = cfg.four_cyc ? 3'd3 : 3'd4;

  always_comb begin
    case (acyc)
      3'd2:    addr_byte = row_lo[7:0];
      3'd3:    addr_byte = row_lo[15:8];
      3'd4:    addr_byte = row_hi;
      default: addr_byte = 8'h00;
    endcase
    if (area_idx == 2'd0) begin
      area_on = cfg.data_en && (DATA_WORDS != '0);
      area_base = dbase;
      area_words = DATA_WORDS;
    end else begin
      area_on = cfg.spare_en && ((slen >> 2) != '0);
      area_base = sbase;
      area_words = slen >> 2;
    end
    if (beats_q != 5'd1)       after_beat = cfg.prog ? S_MRD : S_RXB;
    else if (words_q != '0)    after_beat = S_BURST;
    else                       after_beat = S_AREA;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; acyc <= '0; area_idx <= '0; bidx <= '0;
      addr_q <= '0; words_q <= '0; beats_q <= '0; buf_q <= '0;
    end else begin
      case (st)
        S_IDLE: if (go) st <= S_CMD1;
        S_CMD1: if (tx_ready) begin acyc <= '0; st <= S_ADDR; end
        S_ADDR: if (tx_ready) begin
          acyc <= acyc + 3'd1;
          if (acyc == last_acyc) begin
            area_idx <= '0;
            st <= cfg.prog ? S_AREA : S_CONF_R;
          end
        end
        S_CONF_R: if (tx_ready) st <= S_WAIT_R;
        S_WAIT_R: if (fl_rb) st <= S_AREA;
        S_AREA: begin
          if (area_idx == 2'd2) st <= cfg.prog ? S_CONF_P : S_FIN;
          else if (area_on) begin
            addr_q <= area_base; words_q <= area_words; st <= S_BURST;
          end else area_idx <= area_idx + 2'd1;
        end
        S_BURST: if (cmd_ready) begin
          beats_q <= plan_beats;
          words_q <= words_q - LEN_W'(plan_beats);
          bidx <= '0;
          st <= cfg.prog ? S_MRD : S_RXB;
        end
        S_RXB: if (rx_valid) begin
          buf_q[{bidx, 3'b000} +: 8] <= rx_data;
          bidx <= bidx + 2'd1;
          if (bidx == 2'd3) st <= S_MWR;
        end
        S_MRD: if (rvalid) begin buf_q <= rdata; bidx <= '0; st <= S_TXB; end
        S_MWR, S_TXB: if ((st == S_MWR) ? wready : tx_ready) begin
          bidx <= bidx + 2'd1;
          if (st == S_MWR || bidx == 2'd3) begin
            addr_q <= addr_q + AW'(4);
            beats_q <= beats_q - 5'd1;
            bidx <= '0;
            st <= after_beat;
            if (after_beat == S_AREA) area_idx <= area_idx + 2'd1;
          end
        end
        S_CONF_P: if (tx_ready) st <= S_WAIT_P;
        S_WAIT_P: if (fl_rb) st <= S_FIN;
        S_FIN: st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    tx_valid = 1'b1;
    tx_kind  = TK_CMD;
    tx_data  = cmd_conf;
    case (st)
      S_CMD1: tx_data = cmd_first;
      S_ADDR: begin tx_kind = TK_ADDR; tx_data = addr_byte; end
      S_TXB:  begin tx_kind = TK_DATA; tx_data = buf_q[{bidx, 3'b000} +: 8]; end
      S_CONF_R, S_CONF_P: ;
      default: tx_valid = 1'b0;
    endcase
  end

  assign rx_ready  = (st == S_RXB);
  assign cmd_valid = (st == S_BURST);
  assign cmd_addr  = addr_q;
  assign cmd_beats = plan_beats;
  assign cmd_write = !cfg.prog;
  assign wvalid    = (st == S_MWR);
  assign wdata     = buf_q;
  assign rready    = (st == S_MRD);
  assign done      = (st == S_FIN);

  // R13
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_kind)));
  // R13
  cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_addr) && $stable(cmd_beats)));
  // R7
  beats_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> (cmd_beats != 5'd0 && cmd_beats <= 5'd16 && LEN_W'(cmd_beats) <= words_q));
  // R3
  rx_dir_chk: assert property (@(posedge clk) disable iff (!rst_n) rx_ready |-> !cfg.prog);
  // R5
  rd_dir_chk: assert property (@(posedge clk) disable iff (!rst_n) rready |-> cfg.prog);
endmodule

// File: rtl/nand_page_dma.sv
module nand_page_dma
  import nand_dma_pkg::*;
#(
  parameter int AW         = 32,
  parameter int DATA_BYTES = 2048,
  parameter int LEN_W      = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_we,
  input  logic [RG_W-1:0]      cfg_addr,
  input  logic [31:0]          cfg_wdata,
  output logic [31:0]          cfg_rdata,
  output logic                 irq,
  output logic [(1<<CS_W)-1:0] fl_ce,
  input  logic                 fl_rb,
  output logic                 fl_tx_valid,
  input  logic                 fl_tx_ready,
  output logic [1:0]           fl_tx_kind,
  output logic [7:0]           fl_tx_data,
  input  logic                 fl_rx_valid,
  output logic                 fl_rx_ready,
  input  logic [7:0]           fl_rx_data,
  output logic                 mem_cmd_valid,
  input  logic                 mem_cmd_ready,
  output logic [AW-1:0]        mem_cmd_addr,
  output logic [4:0]           mem_cmd_beats,
  output logic                 mem_cmd_write,
  output logic                 mem_wvalid,
  input  logic                 mem_wready,
  output logic [31:0]          mem_wdata,
  input  logic                 mem_rvalid,
  output logic                 mem_rready,
  input  logic [31:0]          mem_rdata
);
  localparam int NUM_CE = 1 << CS_W;

  xfer_cfg_t        cfg;
  logic [7:0]       cmd_first, cmd_conf, row_hi;
  logic [15:0]      row_lo;
  logic [AW-1:0]    dbase, sbase;
  logic [LEN_W-1:0] slen;
  logic             go, busy, done;
  tx_kind_e         kind;

  nand_dma_regs #(.AW(AW), .LEN_W(LEN_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .rdata(cfg_rdata), .irq(irq), .cfg(cfg), .cmd_first(cmd_first), .cmd_conf(cmd_conf),
    .row_lo(row_lo), .row_hi(row_hi), .dbase(dbase), .sbase(sbase), .slen(slen),
    .go(go), .busy(busy), .done(done)
  );

  nand_dma_seq #(.AW(AW), .LEN_W(LEN_W), .DATA_BYTES(DATA_BYTES)) u_seq (
    .clk(clk), .rst_n(rst_n), .cfg(cfg), .cmd_first(cmd_first), .cmd_conf(cmd_conf),
    .row_lo(row_lo), .row_hi(row_hi), .dbase(dbase), .sbase(sbase), .slen(slen),
    .go(go), .done(done), .fl_rb(fl_rb),
    .tx_valid(fl_tx_valid), .tx_ready(fl_tx_ready), .tx_kind(kind), .tx_data(fl_tx_data),
    .rx_valid(fl_rx_valid), .rx_ready(fl_rx_ready), .rx_data(fl_rx_data),
    .cmd_valid(mem_cmd_valid), .cmd_ready(mem_cmd_ready), .cmd_addr(mem_cmd_addr),
    .cmd_beats(mem_cmd_beats), .cmd_write(mem_cmd_write),
    .wvalid(mem_wvalid), .wready(mem_wready), .wdata(mem_wdata),
    .rvalid(mem_rvalid), .rready(mem_rready), .rdata(mem_rdata)
  );

  assign fl_tx_kind = kind;

  for (genvar i = 0; i < NUM_CE; i++) begin : g_ce
    assign fl_ce[i] = busy && (cfg.cs == CS_W'(i));
  end

  // R12
  ce_busy_chk: assert property (@(posedge clk) disable iff (!rst_n) busy |-> $onehot(fl_ce));
  // R12
  ce_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> (fl_ce == '0));
endmodule

// File: tb/nand_page_dma_tb.sv
module nand_page_dma_tb;
  localparam int DB = 64;
  localparam int DW = DB / 4;

  logic clk = 0, rst_n = 0;
  logic cfg_we = 0;
  logic [3:0] cfg_addr = 0;
  logic [31:0] cfg_wdata = 0, cfg_rdata;
  logic irq, fl_rb = 1;
  logic [3:0] fl_ce;
  logic fl_tx_valid, fl_tx_ready = 0;
  logic [1:0] fl_tx_kind;
  logic [7:0] fl_tx_data;
  logic fl_rx_valid = 0, fl_rx_ready;
  logic [7:0] fl_rx_data = 0;
  logic mem_cmd_valid, mem_cmd_ready = 0, mem_cmd_write;
  logic [31:0] mem_cmd_addr;
  logic [4:0] mem_cmd_beats;
  logic mem_wvalid, mem_wready = 0;
  logic [31:0] mem_wdata;
  logic mem_rvalid = 0, mem_rready;
  logic [31:0] mem_rdata = 0;

  nand_page_dma #(.DATA_BYTES(DB)) u_dut (.*);

  always #2 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit fin = 0;
  logic [31:0] mem [0:1023];
  logic [7:0] page [0:255];
  logic [1:0] txk [0:511];
  logic [7:0] txd [0:511];
  int txn, bn, rxptr, rxlim, bl, busy_cnt, rx_early;
  logic [31:0] bs_addr [0:255];
  logic [4:0] bs_beats [0:255];
  logic bs_we [0:255];
  logic [3:0] ce_seen;
  logic [7:0] cur_conf;
  bit conf_seen, rx_taken, r_taken, bwe;
  int baddr;

  task automatic chk(input bit ok, input string rq, input string what, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  // flash and memory agents, all driven away from the active edge
  always @(negedge clk) if (rst_n) begin
    fl_tx_ready = ($urandom % 4) != 0;
    if (fl_tx_valid && fl_tx_ready) begin
      txk[txn] = fl_tx_kind; txd[txn] = fl_tx_data;
      if (txn == 0) ce_seen = fl_ce;
      txn++;
      if (fl_tx_kind == 2'd0 && fl_tx_data == cur_conf) begin
        fl_rb = 0; busy_cnt = 2 + $urandom % 5; conf_seen = 1;
      end
    end else if (!fl_rb) begin
      if (busy_cnt == 0) fl_rb = 1; else busy_cnt--;
    end
    if (rx_taken) begin fl_rx_valid = 0; rx_taken = 0; end
    if (!fl_rx_valid && rxptr < rxlim && ($urandom % 3) != 0) begin
      fl_rx_valid = 1; fl_rx_data = page[rxptr];
    end
    if (fl_rx_valid && fl_rx_ready) begin
      if (!fl_rb || !conf_seen) rx_early++;
      rxptr++; rx_taken = 1;
    end
    if (r_taken) begin mem_rvalid = 0; r_taken = 0; end
    if (bl > 0 && !bwe) begin
      mem_wready = 0;
      if (!mem_rvalid && ($urandom % 2)) begin mem_rvalid = 1; mem_rdata = mem[baddr]; end
      if (mem_rvalid && mem_rready) begin r_taken = 1; baddr = (baddr + 1) % 1024; bl--; end
    end else if (bl > 0 && bwe) begin
      mem_wready = ($urandom % 3) != 0;
      if (mem_wvalid && mem_wready) begin mem[baddr] = mem_wdata; baddr = (baddr + 1) % 1024; bl--; end
    end else mem_wready = 0;
    mem_cmd_ready = (bl == 0) && ($urandom % 2);
    if (mem_cmd_valid && mem_cmd_ready) begin
      bs_addr[bn] = mem_cmd_addr; bs_beats[bn] = mem_cmd_beats; bs_we[bn] = mem_cmd_write; bn++;
      bl = mem_cmd_beats; baddr = (mem_cmd_addr >> 2) % 1024; bwe = mem_cmd_write;
    end
  end

  task automatic reg_wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic reg_rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); cfg_addr = a; #1; d = cfg_rdata;
  endtask

  function automatic int max_beats(input logic [2:0] b);
    return b[2] ? 16 : b[1] ? 8 : b[0] ? 4 : 1;
  endfunction

  task automatic run_op(input bit prog, input bit den, input bit sen, input logic [2:0] bur,
                        input bit a4, input logic [1:0] cs, input int slen, input bit ien, input bit midwr);
    logic [7:0] ek [0:511];
    logic [7:0] ed [0:511];
    int en = 0, eb = 0, off = 0, bad = 0, mb;
    logic [31:0] row, rowhi, dbase, sbase, d, exp_w;
    int wbase [2];
    int wcnt [2];
    bit aon [2];
    logic [7:0] c1, c2;
    row = $urandom; rowhi = $urandom % 256;
    dbase = 32'h400 + ($urandom % 8) * 4; sbase = 32'h800 + ($urandom % 8) * 4;
    c1 = prog ? 8'h80 : 8'h00; c2 = prog ? 8'h10 : 8'h30;
    aon[0] = den; aon[1] = sen && (slen / 4 > 0);
    wbase[0] = dbase >> 2; wbase[1] = sbase >> 2; wcnt[0] = DW; wcnt[1] = slen / 4;
    for (int i = 0; i < 256; i++) page[i] = $urandom;
    for (int i = 256; i < 1024; i++) mem[i] = $urandom;
    txn = 0; bn = 0; rxptr = 0; rx_early = 0; conf_seen = 0; cur_conf = c2;
    rxlim = prog ? 0 : (aon[0] ? DB : 0) + (aon[1] ? slen : 0);
    // expected flash byte sequence
    ek[en] = 0; ed[en++] = c1;
    ek[en] = 1; ed[en++] = 0; ek[en] = 1; ed[en++] = 0;
    ek[en] = 1; ed[en++] = row[23:16]; ek[en] = 1; ed[en++] = row[31:24];
    if (!a4) begin ek[en] = 1; ed[en++] = rowhi[7:0]; end
    if (!prog) begin ek[en] = 0; ed[en++] = c2; end
    if (prog) begin
      for (int a = 0; a < 2; a++) if (aon[a])
        for (int w = 0; w < wcnt[a]; w++)
          for (int b = 0; b < 4; b++) begin ek[en] = 2; ed[en++] = mem[wbase[a] + w][8*b +: 8]; end
      ek[en] = 0; ed[en++] = c2;
    end
    reg_wr(4'd1, {16'h0, c2, c1});
    reg_wr(4'd2, row);
    reg_wr(4'd3, rowhi);
    reg_wr(4'd4, dbase);
    reg_wr(4'd5, sbase);
    reg_wr(4'd6, (slen << 16) | ($urandom % 65536));
    reg_wr(4'd7, ien ? 32'h200 : 32'h0);
    reg_wr(4'd0, {22'h0, cs, a4, bur, sen, den, prog, 1'b1});
    reg_rd(4'd0, d);
    chk(d[0] == 1, "R8", "start bit while running", d[0], 1);
    if (midwr) begin
      reg_wr(4'd4, 32'h0000_0ff0);
      reg_wr(4'd0, 32'h0);
    end
    for (int k = 0; k < 20000; k++) begin
      reg_rd(4'd0, d);
      if (d[0] == 0) break;
    end
    chk(d[0] == 0, "R8", "start bit clears at end", d[0], 0);
    if (midwr) begin
      reg_rd(4'd4, d);
      chk(d == dbase, "R11", "base write while busy ignored", d, dbase);
      reg_rd(4'd0, d);
      chk(d[9:1] == {cs, a4, bur, sen, den, prog}, "R11", "control write while busy ignored",
          d[9:1], {cs, a4, bur, sen, den, prog});
    end
    bad = (txn != en);
    for (int i = 0; i < en && i < txn; i++) if (txk[i] != ek[i] || txd[i] != ed[i]) bad++;
    chk(bad == 0, prog ? "R5" : "R2", "flash byte sequence (count)", txn, en);
    chk(ce_seen == (4'd1 << cs), "R12", "chip enable", ce_seen, 4'd1 << cs);
    if (!prog) begin
      chk(rx_early == 0, "R3", "bytes taken before ready", rx_early, 0);
      bad = 0;
      for (int a = 0; a < 2; a++) if (aon[a]) begin
        for (int w = 0; w < wcnt[a]; w++) begin
          exp_w = {page[off + 4*w + 3], page[off + 4*w + 2], page[off + 4*w + 1], page[off + 4*w]};
          if (mem[wbase[a] + w] !== exp_w) bad++;
        end
        off += 4 * wcnt[a];
      end
      chk(bad == 0 && rxptr == rxlim, "R4", "packed words in memory (bad words)", bad, 0);
    end
    mb = max_beats(bur); bad = 0;
    for (int a = 0; a < 2; a++) if (aon[a]) begin
      int w = wcnt[a], ad = wbase[a] * 4;
      while (w > 0) begin
        int b = (w < mb) ? w : mb;
        if (eb >= bn || bs_addr[eb] != ad || bs_beats[eb] != b || bs_we[eb] != !prog) bad++;
        eb++; ad += 4 * b; w -= b;
      end
    end
    chk(bad == 0 && eb == bn, (den && sen) ? "R7" : "R6", "burst list (count)", bn, eb);
    reg_rd(4'd8, d);
    chk(d[9] == 1, "R9", "done status set", d[9], 1);
    chk(irq == ien, "R10", "irq follows enable", irq, ien);
    reg_wr(4'd9, 32'h200);
    reg_rd(4'd8, d);
    chk(d[9] == 0, "R9", "done status cleared", d[9], 0);
    chk(irq == 0, "R10", "irq low after clear", irq, 0);
  endtask

  initial begin
    logic [31:0] d;
    void'($urandom(32'd20240613));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    for (int a = 0; a < 10; a++) begin
      reg_rd(a[3:0], d);
      chk(d == 0, "R1", "register reset value", d, 0);
    end
    chk(irq == 0 && fl_ce == 0 && !fl_tx_valid && !mem_cmd_valid && !mem_wvalid, "R1", "idle outputs",
        {irq, fl_ce, fl_tx_valid, mem_cmd_valid, mem_wvalid}, 0);
    // directed corners
    run_op(0, 1, 1, 3'b111, 1, 2'd0, 64, 1, 0);
    run_op(1, 1, 1, 3'b011, 0, 2'd3, 20, 1, 0);
    run_op(0, 0, 0, 3'b001, 0, 2'd1, 16, 0, 0);
    run_op(1, 0, 1, 3'b000, 1, 2'd2, 12, 1, 0);
    run_op(0, 1, 1, 3'b001, 0, 2'd2, 0, 1, 0);
    run_op(1, 1, 0, 3'b100, 0, 2'd1, 8, 0, 1);
    // constrained random
    for (int t = 0; t < 10; t++)
      run_op($urandom % 2, ($urandom % 4) != 0, ($urandom % 4) != 0, $urandom % 8, $urandom % 2,
             $urandom % 4, ($urandom % 17) * 4, $urandom % 2, 0);
    fin = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!fin) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule